// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits between a byte-wide memory-mapped host bus and the control pins of a raw NAND flash device. The host sees two address spaces. A small configuration space, selected by a dedicated select input, holds a window enable bit and a 32-bit base address that the host can write one byte at a time. An operational window of 256 bytes then opens at that base. It holds a data port, a mode byte, a status byte, an interrupt status byte and an interrupt mask byte.

The mode byte drives the command-latch and address-latch enables, the active-low chip enable and the write-protect pin, all as levels. Its two-bit field also commands an external ECC engine to accumulate, deliver its result or clear. A data write puts a byte on the flash output bus together with a one-cycle write strobe. A data read raises a read strobe and returns the flash input byte. Hardware events set interrupt status bits, the host clears them by writing ones, and a single interrupt line combines status with a mask that carries its own master-enable bit.

Every host access takes one cycle. Writes take effect at the clock edge that ends the request cycle. Read data appears on the read-data output one cycle after the request and holds until the next read.

Top module: `nand_host_regs`

## Requirements
- R1: After reset the window is disabled, the base is 0, the mode, interrupt status and mask bytes are 0, the chip-enable output is high, the latch, write-protect, strobe, ECC and interrupt outputs are low, and the read data is 0x00.
- R2: Configuration offset 0x04: a write copies data bit 1 into the window enable. A read returns 0x02 when the window is enabled and 0x00 when it is disabled, whatever other bits were written.
- R3: Configuration offsets 0x10, 0x11, 0x12 and 0x13 each hold one byte of the 32-bit base, least significant byte at 0x10. A write changes only its own byte, and each offset reads back its byte. Other configuration offsets read 0x00.
- R4: An operational access is accepted only when the window is enabled and the bus address with its low 8 bits forced to zero equals the base. Any other operational read returns 0x00, and any other operational write changes nothing.
- R5: Operational offset 0x04 is the mode byte and reads back as written. Bit 0 drives the command-latch output, bit 1 the address-latch output and bit 7 the write-protect output. The chip-enable output is low exactly when bit 4 is 1.
- R6: Mode bits 6:5 form the ECC command. While they hold 01 the accumulate output is high. A mode write with 10 gives a one-cycle result-read pulse, and one with 11 gives a one-cycle clear pulse, each in the cycle after the write. The value 00 drives none of these outputs.
- R7: A write to offset 0x00 puts the byte on the flash output bus, which holds it until the next data write, and raises the write strobe for exactly the next cycle.
- R8: A read of offset 0x00 raises the read strobe during the request cycle and returns the flash input byte sampled at the end of that cycle.
- R9: A read of offset 0x05 returns the flash ready input in bit 0 and zeros in bits 7:1.
- R10: Offset 0x06 is interrupt status. An event input bit sets its status bit, and writing 1 to a bit clears it. When an event and a clear land on the same bit in the same cycle, the bit ends up set. Offset 0x07 is the interrupt mask and reads back as written.
- R11: The interrupt output is high exactly when mask bit 7 is 1 and the bitwise AND of mask and status is nonzero. It follows every change of either byte in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Host access request, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_cfg_i | input | 1 | 1 selects configuration space, 0 the operational window |
| bus_addr_i | input | 32 | Access address (low byte is the offset) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read request |
| fl_data_o | output | 8 | Flash output data bus |
| fl_wr_stb_o | output | 1 | Flash write strobe |
| fl_data_i | input | 8 | Flash input data bus |
| fl_rd_stb_o | output | 1 | Flash read strobe |
| fl_rdy_i | input | 1 | Flash ready |
| fl_cle_o | output | 1 | Command latch enable |
| fl_ale_o | output | 1 | Address latch enable |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_wp_o | output | 1 | Write protect |
| ecc_acc_o | output | 1 | ECC accumulate enable (level) |
| ecc_rd_o | output | 1 | ECC result read pulse |
| ecc_clr_o | output | 1 | ECC clear pulse |
| evt_i | input | 8 | Hardware events, one per interrupt status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision that matters is a host write-one-to-clear on the interrupt status byte in the same cycle as a hardware event on the same bit. The bench forces this in a directed step and then reads the byte back, expecting the bit to stay set. It also puts sparse random events under a stream of random status writes, where the reference model, which clears first and then merges events, is compared with the design on every clock. A second overlap, a status read in the cycle an event arrives, is judged against the pre-event value.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  localparam int REG_W = 8;

  // operational window offsets
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h05;
  localparam logic [7:0] OFS_ISR  = 8'h06;
  localparam logic [7:0] OFS_IMR  = 8'h07;

  // configuration space offsets
  localparam logic [7:0] CFG_CMD  = 8'h04;
  localparam logic [7:0] CFG_BASE = 8'h10;
  localparam int         CFG_EN_BIT = 1;

  // mode byte fields
  localparam int MODE_CLE = 0;
  localparam int MODE_ALE = 1;
  localparam int MODE_SEL = 4;
  localparam int MODE_ECC_LO = 5;
  localparam int MODE_WP  = 7;

  // interrupt mask master enable
  localparam int IMR_MASTER = 7;

  typedef enum logic [1:0] {
    ECC_IDLE  = 2'b00,
    ECC_ACCUM = 2'b01,
    ECC_READ  = 2'b10,
    ECC_RESET = 2'b11
  } ecc_cmd_e;

endpackage

// File: rtl/nand_cfg_space.sv
module nand_cfg_space
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        ofs_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        rdata_o,
  output logic              hit_o
);

  localparam int BYTES = ADDR_W / 8;

  logic                       en_q;
  logic [BYTES-1:0][7:0]      base_q;
  logic [ADDR_W-1:0]          base_flat;

  assign base_flat = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= 1'b0;
    else if (we_i && ofs_i == CFG_CMD)  en_q <= wdata_i[CFG_EN_BIT];
  end

  // one register per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        base_q[g] <= '0;
      else if (we_i && ofs_i == 8'(CFG_BASE + g))
        base_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ofs_i == CFG_CMD) rdata_o[CFG_EN_BIT] = en_q;
    for (int i = 0; i < BYTES; i++)
      if (ofs_i == 8'(CFG_BASE + i)) rdata_o = base_q[i];
  end

  // base with nonzero low byte can never match an aligned address
  assign hit_o = en_q && (base_flat[7:0] == 8'h00)
               && (addr_i[ADDR_W-1:8] == base_flat[ADDR_W-1:8]);

endmodule

// File: rtl/nand_mode_ctrl.sv
module nand_mode_ctrl
  import nand_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] mode_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       ce_no,
  output logic       wp_o,
  output logic       ecc_acc_o,
  output logic       ecc_rd_o,
  output logic       ecc_clr_o
);

  logic [7:0] mode_q;
  logic       rd_q, clr_q;
  ecc_cmd_e   cur_cmd, new_cmd;

  assign cur_cmd = ecc_cmd_e'(mode_q[MODE_ECC_LO +: 2]);
  assign new_cmd = ecc_cmd_e'(wdata_i[MODE_ECC_LO +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rd_q   <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      rd_q  <= we_i && (new_cmd == ECC_READ);
      clr_q <= we_i && (new_cmd == ECC_RESET);
      if (we_i) mode_q <= wdata_i;
    end
  end

  assign mode_o    = mode_q;
  assign cle_o     = mode_q[MODE_CLE];
  assign ale_o     = mode_q[MODE_ALE];
  assign ce_no     = ~mode_q[MODE_SEL];
  assign wp_o      = mode_q[MODE_WP];
  assign ecc_acc_o = (cur_cmd == ECC_ACCUM);
  assign ecc_rd_o  = rd_q;
  assign ecc_clr_o = clr_q;

endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl
  import nand_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             isr_we_i,
  input  logic             imr_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] evt_i,
  output logic [REG_W-1:0] isr_o,
  output logic [REG_W-1:0] imr_o,
  output logic             irq_o
);

  logic [REG_W-1:0] isr_q, imr_q, clr_mask;

  assign clr_mask = isr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~clr_mask) | evt_i;  // set wins over clear
      if (imr_we_i) imr_q <= wdata_i;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = imr_q[IMR_MASTER] && |(imr_q & isr_q);

endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_cfg_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [7:0]        fl_data_o,
  output logic              fl_wr_stb_o,
  input  logic [7:0]        fl_data_i,
  output logic              fl_rd_stb_o,
  input  logic              fl_rdy_i,
  output logic              fl_cle_o,
  output logic              fl_ale_o,
  output logic              fl_ce_no,
  output logic              fl_wp_o,
  output logic              ecc_acc_o,
  output logic              ecc_rd_o,
  output logic              ecc_clr_o,
  input  logic [7:0]        evt_i,
  output logic              irq_o
);

  logic [7:0] ofs;
  logic       cfg_acc, op_acc, win_hit;
  logic       data_wr, data_rd, mode_we, isr_we, imr_we;
  logic [7:0] cfg_rdata, op_rdata, rdata_d, rdata_q;
  logic [7:0] mode_q, isr_q, imr_q;
  logic [7:0] dout_q;
  logic       wstb_q;

  assign ofs     = bus_addr_i[7:0];
  assign cfg_acc = bus_req_i && bus_cfg_i;
  assign op_acc  = bus_req_i && !bus_cfg_i && win_hit;

  assign data_wr = op_acc &&  bus_we_i && (ofs == OFS_DATA);
  assign data_rd = op_acc && !bus_we_i && (ofs == OFS_DATA);
  assign mode_we = op_acc &&  bus_we_i && (ofs == OFS_MODE);
  assign isr_we  = op_acc &&  bus_we_i && (ofs == OFS_ISR);
  assign imr_we  = op_acc &&  bus_we_i && (ofs == OFS_IMR);

  nand_cfg_space #(.ADDR_W(ADDR_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_acc && bus_we_i),
    .ofs_i   (ofs),
    .wdata_i (bus_wdata_i),
    .addr_i  (bus_addr_i),
    .rdata_o (cfg_rdata),
    .hit_o   (win_hit)
  );

  nand_mode_ctrl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mode_we),
    .wdata_i   (bus_wdata_i),
    .mode_o    (mode_q),
    .cle_o     (fl_cle_o),
    .ale_o     (fl_ale_o),
    .ce_no     (fl_ce_no),
    .wp_o      (fl_wp_o),
    .ecc_acc_o (ecc_acc_o),
    .ecc_rd_o  (ecc_rd_o),
    .ecc_clr_o (ecc_clr_o)
  );

  nand_irq_ctrl u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .isr_we_i (isr_we),
    .imr_we_i (imr_we),
    .wdata_i  (bus_wdata_i),
    .evt_i    (evt_i),
    .isr_o    (isr_q),
    .imr_o    (imr_q),
    .irq_o    (irq_o)
  );

  // flash data path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      wstb_q <= 1'b0;
    end else begin
      wstb_q <= data_wr;
      if (data_wr) dout_q <= bus_wdata_i;
    end
  end

  assign fl_data_o   = dout_q;
  assign fl_wr_stb_o = wstb_q;
  assign fl_rd_stb_o = data_rd;

  // read return
  always_comb begin
    unique case (ofs)
      OFS_DATA: op_rdata = fl_data_i;
      OFS_MODE: op_rdata = mode_q;
      OFS_STAT: op_rdata = {7'b0, fl_rdy_i};
      OFS_ISR:  op_rdata = isr_q;
      OFS_IMR:  op_rdata = imr_q;
      default:  op_rdata = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_req_i && !bus_we_i) begin
      if (bus_cfg_i)    rdata_d = cfg_rdata;
      else if (win_hit) rdata_d = op_rdata;
      else              rdata_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/nand_host_regs_chk.sv
module nand_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_req_i,
  input logic       bus_we_i,
  input logic       bus_cfg_i,
  input logic       win_hit,
  input logic       data_wr,
  input logic [7:0] mode_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q,
  input logic [7:0] evt_i,
  input logic       irq_o,
  input logic       fl_wr_stb_o,
  input logic       fl_rd_stb_o,
  input logic       ecc_acc_o,
  input logic       ecc_rd_o,
  input logic       ecc_clr_o
);

  // R4
  outside_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && !bus_cfg_i && !win_hit) |=> $stable(mode_q));

  // R6
  ecc_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ecc_acc_o, ecc_rd_o, ecc_clr_o}));

  // R7
  wr_strobe_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> fl_wr_stb_o);

  // R8
  rd_strobe_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_rd_stb_o |-> (bus_req_i && !bus_we_i && !bus_cfg_i && win_hit));

  // R10
  event_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != 8'h00) |=> ((isr_q & $past(evt_i)) == $past(evt_i)));

  // R11
  irq_master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (imr_q[7] && (isr_q != 8'h00)));

endmodule

bind nand_host_regs nand_host_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_cfg_i   (bus_cfg_i),
  .win_hit     (win_hit),
  .data_wr     (data_wr),
  .mode_q      (mode_q),
  .isr_q       (isr_q),
  .imr_q       (imr_q),
  .evt_i       (evt_i),
  .irq_o       (irq_o),
  .fl_wr_stb_o (fl_wr_stb_o),
  .fl_rd_stb_o (fl_rd_stb_o),
  .ecc_acc_o   (ecc_acc_o),
  .ecc_rd_o    (ecc_rd_o),
  .ecc_clr_o   (ecc_clr_o)
);

// File: tb/nand_host_regs_test.sv
module nand_host_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, cfg = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0, fl_din = '0, evt = '0;
  logic        rdy = 1'b0;
  logic [7:0]  rdata, fl_dout;
  logic        wstb, rstb, cle, ale, ce_n, wp, acc, eccrd, eccclr, irq;

  integer n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  nand_host_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_cfg_i(cfg),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fl_data_o(fl_dout), .fl_wr_stb_o(wstb), .fl_data_i(fl_din), .fl_rd_stb_o(rstb),
    .fl_rdy_i(rdy), .fl_cle_o(cle), .fl_ale_o(ale), .fl_ce_no(ce_n), .fl_wp_o(wp),
    .ecc_acc_o(acc), .ecc_rd_o(eccrd), .ecc_clr_o(eccclr), .evt_i(evt), .irq_o(irq)
  );

  // behavioural reference
  bit          m_en;
  bit   [31:0] m_base;
  bit   [7:0]  m_mode, m_isr, m_imr, m_rdata, m_dout;
  bit          m_wstb, m_eccrd, m_eccclr;

  function automatic bit m_hit(input bit [31:0] a);
    return m_en && ((a & 32'hFFFF_FF00) == m_base);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_base = 0; m_mode = 0; m_isr = 0; m_imr = 0;
      m_rdata = 0; m_dout = 0; m_wstb = 0; m_eccrd = 0; m_eccclr = 0;
    end else begin
      int o;
      bit h;
      o = int'(addr[7:0]);
      h = m_hit(addr);
      m_wstb = 0; m_eccrd = 0; m_eccclr = 0;
      if (req && !we) begin
        m_rdata = 0;
        if (cfg) begin
          if (o == 4) m_rdata = m_en ? 8'h02 : 8'h00;
          else if (o >= 16 && o <= 19) m_rdata = 8'(m_base >> (8 * (o - 16)));
        end else if (h) begin
          case (o)
            0: m_rdata = fl_din;
            4: m_rdata = m_mode;
            5: m_rdata = {7'd0, rdy};
            6: m_rdata = m_isr;
            7: m_rdata = m_imr;
            default: m_rdata = 0;
          endcase
        end
      end
      if (req && we) begin
        if (cfg) begin
          if (o == 4) m_en = wdata[1];
          else if (o >= 16 && o <= 19) begin
            m_base &= ~(32'hFF << (8 * (o - 16)));
            m_base |= 32'(wdata) << (8 * (o - 16));
          end
        end else if (h) begin
          case (o)
            0: begin m_dout = wdata; m_wstb = 1; end
            4: begin
              m_mode = wdata;
              m_eccrd  = (wdata / 32) % 4 == 2;
              m_eccclr = (wdata / 32) % 4 == 3;
            end
            6: m_isr &= ~wdata;
            7: m_imr = wdata;
            default: ;
          endcase
        end
      end
      m_isr |= evt;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison, mid low phase
  always @(negedge clk) begin
    if (rst_n) begin
      #3;
      chk("R4 rdata", rdata, m_rdata);
      chk("R5 cle", cle, m_mode[0]);
      chk("R5 ale", ale, m_mode[1]);
      chk("R5 wp", wp, m_mode[7]);
      chk("R5 ce_n", ce_n, !m_mode[4]);
      chk("R6 acc", acc, (m_mode / 32) % 4 == 1);
      chk("R6 eccrd", eccrd, m_eccrd);
      chk("R6 eccclr", eccclr, m_eccclr);
      chk("R7 wstb", wstb, m_wstb);
      chk("R7 dout", fl_dout, m_dout);
      chk("R8 rstb", rstb, req && !we && !cfg && m_hit(addr) && addr[7:0] == 0);
      chk("R11 irq", irq, m_imr[7] && ((m_imr & m_isr) != 0));
    end
  end

  localparam bit [31:0] BASE = 32'h4000_2300;

  task automatic acc_cyc(input bit c, input bit w, input bit [31:0] a, input bit [7:0] d);
    @(negedge clk);
    req = 1; we = w; cfg = c; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; evt = 0;
  endtask

  task automatic rd_chk(input bit c, input bit [31:0] a, input string tag, input int exp);
    acc_cyc(c, 0, a, 8'h00);
    #3 chk(tag, rdata, exp);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    // R1 reset state
    chk("R1 rdata", rdata, 0); chk("R1 ce_n", ce_n, 1); chk("R1 irq", irq, 0);
    chk("R1 wstb", wstb, 0); chk("R1 cle", cle, 0); chk("R1 acc", acc, 0);

    // R2 enable bit
    rd_chk(1, 32'h04, "R2 disabled", 8'h00);
    acc_cyc(1, 1, 32'h04, 8'h02);
    rd_chk(1, 32'h04, "R2 enabled", 8'h02);
    acc_cyc(1, 1, 32'h04, 8'hFD);
    rd_chk(1, 32'h04, "R2 cleared", 8'h00);
    acc_cyc(1, 1, 32'h04, 8'hFF);
    rd_chk(1, 32'h04, "R2 other bits", 8'h02);

    // R3 base lanes
    acc_cyc(1, 1, 32'h13, 8'h40);
    acc_cyc(1, 1, 32'h11, 8'h23);
    acc_cyc(1, 1, 32'h12, 8'h5A);
    rd_chk(1, 32'h12, "R3 lane2", 8'h5A);
    rd_chk(1, 32'h13, "R3 lane3 kept", 8'h40);
    acc_cyc(1, 1, 32'h12, 8'h00);
    rd_chk(1, 32'h11, "R3 lane1", 8'h23);
    rd_chk(1, 32'h10, "R3 lane0", 8'h00);
    rd_chk(1, 32'h20, "R3 unused cfg", 8'h00);

    // R4 window decode
    acc_cyc(0, 1, BASE + 32'h104, 8'h11);
    chk("R4 outside write ignored", ce_n, 1);
    rd_chk(0, BASE + 32'h100, "R4 outside read", 8'h00);
    acc_cyc(1, 1, 32'h04, 8'h00);
    acc_cyc(0, 1, BASE + 32'h04, 8'h11);
    chk("R4 disabled write ignored", ce_n, 1);
    acc_cyc(1, 1, 32'h04, 8'h02);

    // R5 pins
    acc_cyc(0, 1, BASE + 32'h04, 8'h93);
    chk("R5 cle", cle, 1); chk("R5 ale", ale, 1); chk("R5 wp", wp, 1); chk("R5 ce_n", ce_n, 0);
    rd_chk(0, BASE + 32'h04, "R5 readback", 8'h93);
    acc_cyc(0, 1, BASE + 32'h04, 8'h02);
    chk("R5 ce_n off", ce_n, 1); chk("R5 ale only", ale, 1);

    // R6 ecc
    acc_cyc(0, 1, BASE + 32'h04, 8'h30);
    chk("R6 accumulate", acc, 1);
    @(negedge clk); req = 1; we = 1; addr = BASE + 32'h04; wdata = 8'h50;
    @(negedge clk); req = 0; we = 0; #3;
    chk("R6 read pulse", eccrd, 1);
    @(negedge clk); #3 chk("R6 read pulse ends", eccrd, 0);
    acc_cyc(0, 1, BASE + 32'h04, 8'h70);
    chk("R6 clear pulse", eccclr, 1);
    acc_cyc(0, 1, BASE + 32'h04, 8'h00);
    chk("R6 idle", acc + eccrd + eccclr, 0);

    // R7 data write
    acc_cyc(0, 1, BASE, 8'hA5);
    chk("R7 strobe", wstb, 1); chk("R7 data", fl_dout, 8'hA5);
    @(negedge clk); #3 chk("R7 strobe one cycle", wstb, 0); chk("R7 data held", fl_dout, 8'hA5);

    // R8 data read
    fl_din = 8'h3C;
    @(negedge clk); req = 1; addr = BASE; #3 chk("R8 read strobe", rstb, 1);
    @(negedge clk); req = 0; #3 chk("R8 read data", rdata, 8'h3C);

    // R9 status
    rdy = 1; rd_chk(0, BASE + 32'h05, "R9 ready", 8'h01);
    rdy = 0; rd_chk(0, BASE + 32'h05, "R9 busy", 8'h00);

    // R10 status bits
    @(negedge clk); evt = 8'h05; @(negedge clk); evt = 0;
    rd_chk(0, BASE + 32'h06, "R10 event set", 8'h05);
    acc_cyc(0, 1, BASE + 32'h06, 8'h01);
    rd_chk(0, BASE + 32'h06, "R10 w1c", 8'h04);
    @(negedge clk); req = 1; we = 1; addr = BASE + 32'h06; wdata = 8'h04; evt = 8'h04;
    @(negedge clk); req = 0; we = 0; evt = 0;
    rd_chk(0, BASE + 32'h06, "R10 set wins", 8'h04);
    acc_cyc(0, 1, BASE + 32'h07, 8'h84);
    rd_chk(0, BASE + 32'h07, "R10 mask readback", 8'h84);

    // R11 irq
    chk("R11 irq on", irq, 1);
    acc_cyc(0, 1, BASE + 32'h07, 8'h04);
    chk("R11 master off", irq, 0);
    acc_cyc(0, 1, BASE + 32'h07, 8'h80);
    chk("R11 no overlap", irq, 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      @(negedge clk);
      k = $urandom % 10;
      evt = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      fl_din = 8'($urandom); rdy = 1'($urandom);
      req = (k != 0); we = 1'($urandom); wdata = 8'($urandom);
      cfg = (k == 1);
      if (k == 1) begin
        addr = we ? 32'h04 : 32'(8'h10 + ($urandom % 4));
        if (we) wdata = (($urandom % 4) == 0) ? 8'h00 : 8'h02;
      end else if (k == 2) addr = BASE + 32'h200 + 32'($urandom % 8);
      else addr = BASE + 32'($urandom % 8);
    end
    @(negedge clk); req = 0; we = 0; cfg = 0; evt = 0;
    repeat (3) @(negedge clk);
    #4 finish_run();
  end

endmodule